// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block takes six event inputs from an industrial fieldbus slave subsystem and turns them into four interrupt lines and one DMA request. Each event rising edge is latched into a sticky raw status bit. Software can also force a raw bit high, or clear it by writing a 1. A mask register selects which raw bits reach the masked status and the interrupt lines.

There is one status copy, and every bus master on the register port reaches it. A clear from any master therefore retires the cause for all of them. Three causes share a general line: the application-layer request, the interface watchdog timeout and the DMA-done event. The reset-out request, SYNC0 and SYNC1 each have a line of their own. The two SYNC events also pulse a DMA request that ignores the mask.

Event inputs pass through a configurable synchronizer before edge detection. Register reads are combinational from the address. Writes take effect at the clock edge where `req_i` and `we_i` are high.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, raw status, mask and masked status all read 0, and all interrupt and DMA outputs are 0.
- R2: A rising edge on `evt_i[n]` sets raw bit n exactly SYNC_STAGES+1 clock edges after the input rises. The bit stays set after the input falls. An input held high does not set the bit again once it has been cleared. The cause bit order is: 0 application-layer request, 1 watchdog timeout, 2 DMA done, 3 reset-out, 4 SYNC0, 5 SYNC1.
- R3: Writing to byte offset 0xC clears each raw bit whose data bit is 1, and leaves the raw bits under 0 data bits unchanged.
- R4: Writing to byte offset 0x10 sets each raw bit whose data bit is 1. A data bit of 0 has no effect.
- R5: If a detected event edge or a set of a cause lands in the same cycle as a clear of that cause, the raw bit ends up set.
- R6: The mask is read and written at 0x8. The raw status reads at 0x0. The masked status reads at 0x4 and equals raw AND mask.
- R7: `irq_gen_o` equals the OR of the masked bits 0 to 2. It is delayed by one register stage behind the status.
- R8: `irq_rst_o`, `irq_sync0_o` and `irq_sync1_o` follow masked bits 3, 4 and 5 respectively, one register stage behind. No other cause drives them.
- R9: `dma_sync_o` pulses high for exactly one cycle for each detected rising edge of SYNC0 or SYNC1, in the same cycle as the raw bit sets. The pulse does not depend on the mask. Software sets and falling edges do not produce it.
- R10: An access is ignored when its address has bits [1:0] not 0, or when it targets an offset outside 0x0 to 0x10. Such a read returns 0. The clear and set offsets always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Event inputs, one per cause |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_gen_o | output | 1 | Shared line for causes 0 to 2 |
| irq_rst_o | output | 1 | Reset-out line |
| irq_sync0_o | output | 1 | SYNC0 line |
| irq_sync1_o | output | 1 | SYNC1 line |
| dma_sync_o | output | 1 | SYNC DMA request pulse |

## Verification
The bench builds the block with its default values: SYNC_STAGES=2, ADDR_W=5 and DATA_W=32. With two synchronizer stages, edge detection is three edges deep, so the checks measure the exact cycle at which a raw bit and a DMA pulse appear. They also let the bench place a clear write in the same cycle as a detected edge. A five-bit address reaches the unused offsets above the set register, and misaligned offsets can be hit as well.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int unsigned NC = 6;  // causes
  localparam int unsigned NL = 4;  // interrupt lines

  // word indices of the register map
  localparam int unsigned IDX_RAW  = 0;
  localparam int unsigned IDX_MSK  = 1;
  localparam int unsigned IDX_MASK = 2;
  localparam int unsigned IDX_CLR  = 3;
  localparam int unsigned IDX_SET  = 4;

  // cause -> line: 0 gen, 1 reset-out, 2 sync0, 3 sync1
  localparam int unsigned CAUSE_LINE [NC] = '{0, 0, 0, 1, 2, 3};
  localparam logic [NC-1:0] DMA_CAUSES = 6'b11_0000;
endpackage

// File: rtl/eia_capture.sv
module eia_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [eia_pkg::NC-1:0] evt_i,
  output logic [eia_pkg::NC-1:0] edge_o
);
  import eia_pkg::*;

  logic [NC-1:0] evt_s, prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign evt_s = evt_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0][NC-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else begin
          chain_q[0] <= evt_i;
          for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign evt_s = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= evt_s;
  end

  assign edge_o = evt_s & ~prev_q;
endmodule

// File: rtl/eia_status.sv
module eia_status #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [eia_pkg::NC-1:0] edge_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [eia_pkg::NC-1:0] raw_o,
  output logic [eia_pkg::NC-1:0] mask_o
);
  import eia_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned PAD_W = DATA_W - NC;

  logic [IDX_W-1:0] idx;
  logic             aligned, wr;
  logic [NC-1:0]    wbits, clr_v, set_v, raw_q, mask_q, rd_bits;
  logic             unused_wdata_hi;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign wbits   = wdata_i[NC-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NC];

  assign clr_v = (wr && idx == IDX_W'(IDX_CLR)) ? wbits : '0;
  assign set_v = (wr && idx == IDX_W'(IDX_SET)) ? wbits : '0;

  // event and set win over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_v) | set_v | edge_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr && idx == IDX_W'(IDX_MASK)) mask_q <= wbits;
  end

  always_comb begin
    rd_bits = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(IDX_RAW):  rd_bits = raw_q;
        IDX_W'(IDX_MSK):  rd_bits = raw_q & mask_q;
        IDX_W'(IDX_MASK): rd_bits = mask_q;
        default:          rd_bits = '0;
      endcase
    end
  end

  assign rdata_o = {{PAD_W{1'b0}}, rd_bits};
  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/eia_router.sv
module eia_router (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [eia_pkg::NC-1:0] raw_i,
  input  logic [eia_pkg::NC-1:0] mask_i,
  input  logic [eia_pkg::NC-1:0] edge_i,
  output logic [eia_pkg::NL-1:0] irq_o,
  output logic                   dma_o
);
  import eia_pkg::*;

  logic [NC-1:0] masked;
  logic [NL-1:0] line_d, irq_q;
  logic          dma_q;

  assign masked = raw_i & mask_i;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_line
      logic [NC-1:0] sel;
      for (genvar c = 0; c < NC; c++) begin : g_cause
        assign sel[c] = masked[c] && (CAUSE_LINE[c] == l);
      end
      assign line_d[l] = |sel;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= line_d;
      dma_q <= |(edge_i & DMA_CAUSES);
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [eia_pkg::NC-1:0] evt_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   irq_gen_o,
  output logic                   irq_rst_o,
  output logic                   irq_sync0_o,
  output logic                   irq_sync1_o,
  output logic                   dma_sync_o
);
  import eia_pkg::*;

  logic [NC-1:0] evt_edge, raw_q, mask_q;
  logic [NL-1:0] irq_v;

  eia_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .edge_o (evt_edge)
  );

  eia_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (evt_edge),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .raw_o   (raw_q),
    .mask_o  (mask_q)
  );

  eia_router u_router (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_q),
    .mask_i (mask_q),
    .edge_i (evt_edge),
    .irq_o  (irq_v),
    .dma_o  (dma_sync_o)
  );

  assign irq_gen_o   = irq_v[0];
  assign irq_rst_o   = irq_v[1];
  assign irq_sync0_o = irq_v[2];
  assign irq_sync1_o = irq_v[3];
endmodule

// File: rtl/eia_chk.sv
module eia_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic [eia_pkg::NC-1:0] edge_i,
  input logic [eia_pkg::NC-1:0] raw_i,
  input logic [eia_pkg::NC-1:0] mask_i,
  input logic                   irq_gen_i,
  input logic                   irq_rst_i,
  input logic                   dma_i
);
  import eia_pkg::*;

  logic          wr_clr, wr_set;
  logic [NC-1:0] set_bits;

  assign wr_clr   = req_i && we_i && (addr_i == ADDR_W'(12));
  assign wr_set   = req_i && we_i && (addr_i == ADDR_W'(16));
  assign set_bits = wr_set ? wdata_i[NC-1:0] : '0;

  // R3
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((raw_i & $past(wdata_i[NC-1:0]) & ~$past(edge_i) & ~$past(set_bits)) == '0));

  // R5
  edge_latches_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_i) |=> ((raw_i & $past(edge_i)) == $past(edge_i)));

  // R7
  gen_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_gen_i == $past(|(raw_i[2:0] & mask_i[2:0])));

  // R8
  rst_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rst_i == $past(raw_i[3] & mask_i[3]));

  // R9
  dma_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_i |-> $past(edge_i[4] | edge_i[5]));
endmodule

bind evt_irq_agg eia_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .edge_i    (evt_edge),
  .raw_i     (raw_q),
  .mask_i    (mask_q),
  .irq_gen_i (irq_gen_o),
  .irq_rst_i (irq_rst_o),
  .dma_i     (dma_sync_o)
);

// File: tb/evt_irq_agg_tb.sv
module evt_irq_agg_tb;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    evt = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_gen, irq_rst, irq_s0, irq_s1, dma;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_gen_o(irq_gen),
    .irq_rst_o(irq_rst), .irq_sync0_o(irq_s0), .irq_sync1_o(irq_s1),
    .dma_sync_o(dma)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  function automatic logic [31:0] lines();
    return {28'd0, irq_s1, irq_s0, irq_rst, irq_gen};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h00, v); chk("R1 raw", v, 0);
    rd(5'h04, v); chk("R1 masked", v, 0);
    rd(5'h08, v); chk("R1 mask", v, 0);
    chk("R1 lines", lines(), 0);
    chk("R1 dma", {31'd0, dma}, 0);
  endtask

  task automatic t_edge_sticky;
    logic [31:0] v;
    evt[0] = 1'b1;
    cyc(2); rd(5'h00, v); chk("R2 not yet", v, 0);
    cyc(1); rd(5'h00, v); chk("R2 latched", v, 32'h01);
    evt[0] = 1'b0;
    cyc(3); rd(5'h00, v); chk("R2 sticky", v, 32'h01);
    wr(5'h0C, 32'h01); rd(5'h00, v); chk("R3 cleared", v, 0);
    evt[0] = 1'b1;
    cyc(3); rd(5'h00, v); chk("R2 second edge", v, 32'h01);
    wr(5'h0C, 32'h01);
    cyc(3); rd(5'h00, v); chk("R2 level no retrigger", v, 0);
    evt[0] = 1'b0;
    cyc(2);
  endtask

  task automatic t_clear_set;
    logic [31:0] v;
    wr(5'h10, 32'h25); rd(5'h00, v); chk("R4 set", v, 32'h25);
    wr(5'h10, 32'h00); rd(5'h00, v); chk("R4 zero no effect", v, 32'h25);
    wr(5'h0C, 32'h05); rd(5'h00, v); chk("R3 partial clear", v, 32'h20);
    wr(5'h0C, 32'h20); rd(5'h00, v); chk("R3 clear rest", v, 0);
    wr(5'h08, 32'h2A); rd(5'h08, v); chk("R6 mask rb", v, 32'h2A);
    wr(5'h10, 32'h3F);
    rd(5'h04, v); chk("R6 masked", v, 32'h2A);
    rd(5'h00, v); chk("R6 raw", v, 32'h3F);
    wr(5'h0C, 32'h3F); wr(5'h08, 32'h00); cyc(1);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(5'h10, 32'h06);
    evt[1] = 1'b1;
    cyc(2);
    wr(5'h0C, 32'h06);  // lands with detected edge of cause 1
    rd(5'h00, v); chk("R5 edge beats clear", v, 32'h02);
    wr(5'h0C, 32'h02); rd(5'h00, v); chk("R3 clear after race", v, 0);
    evt[1] = 1'b0; cyc(2);
  endtask

  task automatic t_mask_gen;
    logic [31:0] v;
    wr(5'h08, 32'h02);
    wr(5'h10, 32'h01); cyc(1); chk("R7 masked off", lines(), 0);
    wr(5'h10, 32'h02); chk("R7 one stage", lines(), 0);
    cyc(1); chk("R7 gen on", lines(), 32'h1);
    wr(5'h0C, 32'h02); chk("R7 hold", lines(), 32'h1);
    cyc(1); chk("R7 gen off", lines(), 0);
    wr(5'h08, 32'h04); wr(5'h10, 32'h04); cyc(1);
    chk("R7 dma-done on gen", lines(), 32'h1);
    wr(5'h0C, 32'h3F); wr(5'h08, 32'h00); cyc(1);
    rd(5'h00, v); chk("R7 cleanup", v, 0);
  endtask

  task automatic t_dedicated;
    wr(5'h08, 32'h3F);
    for (int i = 3; i < 6; i++) begin
      wr(5'h10, 32'(1) << i); cyc(1);
      chk($sformatf("R8 line cause %0d", i), lines(), 32'(1) << (i - 2));
      wr(5'h0C, 32'h3F); cyc(1);
      chk("R8 line off", lines(), 0);
    end
    wr(5'h08, 32'h00);
  endtask

  task automatic t_dma;
    evt[4] = 1'b1;
    cyc(3); chk("R9 sync0 pulse", {31'd0, dma}, 1);
    chk("R9 masked irq stays low", lines(), 0);
    cyc(1); chk("R9 one cycle", {31'd0, dma}, 0);
    evt[4] = 1'b0;
    cyc(3); chk("R9 fall no pulse", {31'd0, dma}, 0);
    evt[5] = 1'b1;
    cyc(3); chk("R9 sync1 pulse", {31'd0, dma}, 1);
    cyc(1); chk("R9 sync1 end", {31'd0, dma}, 0);
    evt[5] = 1'b0;
    wr(5'h10, 32'h30); chk("R9 set no pulse", {31'd0, dma}, 0);
    wr(5'h0C, 32'h3F); cyc(2);
  endtask

  task automatic t_addr;
    logic [31:0] v;
    wr(5'h09, 32'h3F); rd(5'h08, v); chk("R10 misaligned write", v, 0);
    wr(5'h10, 32'h11);
    rd(5'h01, v); chk("R10 misaligned read", v, 0);
    rd(5'h0C, v); chk("R10 clear reads 0", v, 0);
    rd(5'h10, v); chk("R10 set reads 0", v, 0);
    wr(5'h14, 32'h3F); rd(5'h00, v); chk("R10 unmapped write", v, 32'h11);
    rd(5'h1C, v); chk("R10 unmapped read", v, 0);
    wr(5'h0C, 32'h3F);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_edge_sticky();
    t_clear_set();
    t_race();
    t_mask_gen();
    t_dedicated();
    t_dma();
    t_addr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule